// File: doc/BRIEF.md
# External Bus Wait-State Controller

This block keeps an 8-bit bus configuration byte and runs the external-memory bus cycle from it. A CPU-side port reads the byte and writes it. A write can replace the whole byte or change single bits, because a bit mask selects which bits take the write data. The byte also drives the pin-function selects: whether the bus pins act as ports or as the address/data bus, whether the four top port latches carry the upper address bits, and whether internal ROM fetches use the fast cycle.

For each access request the sequencer decides how many wait cycles to insert. An access runs through an address phase, zero or more wait phases and a data phase. A one-cycle completion pulse then goes back to the requester. Programmed waits apply only to the lowest 64 KiB of the 1 MiB space. When the wait field selects pin mode, the wait phase lasts as long as the external wait input is held low. When the bus is not in expansion mode, a request completes at once and no bus cycle runs.

Top module: `xbus_wait_ctrl`

## Requirements
- R1: After reset, cfg_rdata reads 0x20. This means mode field [2:0] = 000 (single-chip), wait field [5:4] = 10, upper-address bit [6] = 0 and fast-fetch bit [7] = 0.
- R2: When cfg_we is high, every bit set in cfg_mask takes the matching cfg_wdata bit at the clock edge, and every other bit keeps its value.
- R3: Bit 3 of the register always reads 0, whatever is written to it.
- R4: In expansion mode, an access below 0x10000 with wait field 00, 01 or 10 inserts 0, 1 or 2 wait cycles. The request is taken at a clock edge while the sequencer is idle, and done is high during the cycle that follows the edge (N+2) edges later, where N is the number of wait cycles.
- R5: An access with any of address bits [19:16] set inserts no wait cycles, whatever the wait field says and whatever the wait input does.
- R6: With wait field 11 and an address below 0x10000, ext_wait_n is sampled at the end of the address phase and at the end of each wait cycle. Each low sample adds one wait cycle.
- R7: When mode field [2:0] is not 111 at the edge that takes the request, done is high during the very next cycle and busy stays low.
- R8: done is high for one cycle only. busy is high from the address phase through the data phase and is low again while done is high.
- R9: The wait field is captured at the edge that takes the request. A register write at that same edge, or later during the access, does not change the length of that access.
- R10: bus_pins_en is 1 exactly when mode field [2:0] is 111. Every other mode value, 000 included, gives 0.
- R11: hi_addr_en is 1 exactly when bus_pins_en is 1 and bit 6 is 1.
- R12: fast_fetch equals bit 7 of the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_mask | input | 8 | Bits the write affects |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data |
| req | input | 1 | External access request |
| req_addr | input | 20 | Access address |
| ext_wait_n | input | 1 | External wait input, active low |
| busy | output | 1 | Bus cycle in progress |
| done | output | 1 | One-cycle access completion pulse |
| bus_pins_en | output | 1 | Bus pins carry address/data and strobes |
| hi_addr_en | output | 1 | Top four port latches drive address bits 19:16 |
| fast_fetch | output | 1 | Internal ROM fetches use the fast cycle |

## Verification
Two things can fall on the same clock edge: a register write that changes the wait field, and the sequencer taking a request. The bench provokes this by raising cfg_we and req in the same cycle. It then expects the access length that the old wait field gives, while the read-back shows the new value. A second case writes the wait field during the address phase of a running access. The bench judges both by counting the edges from acceptance to done and comparing that count with its own model.

// File: rtl/xbw_pkg.sv
package xbw_pkg;
   localparam int CFG_W   = 8;
   localparam int WSEL_LO = 4;
   localparam int WSEL_W  = 2;
   localparam int MODE_W  = 3;
   localparam int HIA_BIT = 6;
   localparam int FF_BIT  = 7;
   localparam int RSV_BIT = 3;

   localparam logic [MODE_W-1:0] MODE_EXPAND = 3'b111;
   localparam logic [WSEL_W-1:0] WSEL_PIN    = 2'b11;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ADDR = 2'd1,
      PH_WAIT = 2'd2,
      PH_DATA = 2'd3
   } xbw_phase_e;
endpackage

// File: rtl/xbw_cfg_reg.sv
module xbw_cfg_reg
   import xbw_pkg::*;
#(
   parameter logic [CFG_W-1:0] RESET_VAL = 8'h20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CFG_W-1:0] mask,
   input  logic [CFG_W-1:0] wdata,
   output logic [CFG_W-1:0] q
);
   localparam logic [CFG_W-1:0] KEEP_MASK = ~(CFG_W'(1) << RSV_BIT);

   initial begin
      assert (RESET_VAL[RSV_BIT] == 1'b0)
         else $error("reserved bit must reset to zero");
   end

   logic [CFG_W-1:0] nxt;
   always_comb nxt = ((q & ~mask) | (wdata & mask)) & KEEP_MASK;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RESET_VAL;
      else if (we) q <= nxt;
   end

   assert_masked_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> ((q ^ $past(q)) & ~$past(mask)) == '0);

   assert_rsv_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> !q[RSV_BIT]);
endmodule

// File: rtl/xbw_pinsel.sv
module xbw_pinsel
   import xbw_pkg::*;
(
   input  logic [CFG_W-1:0] cfg,
   output logic             bus_en,
   output logic             hia_en,
   output logic             ffetch
);
   always_comb begin
      bus_en = (cfg[MODE_W-1:0] == MODE_EXPAND);
      hia_en = bus_en & cfg[HIA_BIT];
      ffetch = cfg[FF_BIT];
   end
endmodule

// File: rtl/xbw_seq.sv
module xbw_seq
   import xbw_pkg::*;
#(
   parameter int ADDR_W   = 20,
   parameter int REGION_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic [ADDR_W-1:0] addr,
   input  logic [WSEL_W-1:0] wsel_cfg,
   input  logic              expansion,
   input  logic              ext_wait_n,
   output logic              busy,
   output logic              done
);
   initial begin
      assert (REGION_W >= 1 && REGION_W <= ADDR_W)
         else $error("wait region must fit in the address");
   end

   logic in_region;
   generate
      if (ADDR_W > REGION_W) begin : g_region
         assign in_region = ~|addr[ADDR_W-1:REGION_W];
      end else begin : g_all
         assign in_region = 1'b1;
      end
   endgenerate

   xbw_phase_e        ph;
   logic [WSEL_W-1:0] wsel_q;
   logic [WSEL_W-1:0] cnt;
   logic              pin_mode;

   assign pin_mode = (wsel_q == WSEL_PIN);
   assign busy     = (ph != PH_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph     <= PH_IDLE;
         wsel_q <= '0;
         cnt    <= '0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (ph)
            PH_IDLE: begin
               if (req) begin
                  if (!expansion) begin
                     done <= 1'b1;
                  end else begin
                     ph     <= PH_ADDR;
                     wsel_q <= in_region ? wsel_cfg : '0;
                  end
               end
            end
            PH_ADDR: begin
               if (pin_mode)          ph <= ext_wait_n ? PH_DATA : PH_WAIT;
               else if (wsel_q == '0) ph <= PH_DATA;
               else begin
                  ph  <= PH_WAIT;
                  cnt <= wsel_q - 1'b1;
               end
            end
            PH_WAIT: begin
               if (pin_mode) begin
                  if (ext_wait_n) ph <= PH_DATA;
               end else if (cnt == '0) begin
                  ph <= PH_DATA;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            PH_DATA: begin
               ph   <= PH_IDLE;
               done <= 1'b1;
            end
            default: ph <= PH_IDLE;
         endcase
      end
   end

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_zero_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_ADDR && wsel_q == '0) |=> (ph == PH_DATA));

   assert_pin_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_WAIT && pin_mode && !ext_wait_n) |=> (ph == PH_WAIT));

   assert_single_chip_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_IDLE && req && !expansion) |=> (done && !busy));
endmodule

// File: rtl/xbus_wait_ctrl.sv
module xbus_wait_ctrl
   import xbw_pkg::*;
#(
   parameter int               ADDR_W    = 20,
   parameter int               REGION_W  = 16,
   parameter logic [CFG_W-1:0] RESET_VAL = 8'h20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_W-1:0]  cfg_mask,
   input  logic [CFG_W-1:0]  cfg_wdata,
   output logic [CFG_W-1:0]  cfg_rdata,
   input  logic              req,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              ext_wait_n,
   output logic              busy,
   output logic              done,
   output logic              bus_pins_en,
   output logic              hi_addr_en,
   output logic              fast_fetch
);
   logic [CFG_W-1:0] cfg_q;

   xbw_cfg_reg #(.RESET_VAL(RESET_VAL)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .mask  (cfg_mask),
      .wdata (cfg_wdata),
      .q     (cfg_q)
   );

   xbw_pinsel u_pins (
      .cfg    (cfg_q),
      .bus_en (bus_pins_en),
      .hia_en (hi_addr_en),
      .ffetch (fast_fetch)
   );

   xbw_seq #(.ADDR_W(ADDR_W), .REGION_W(REGION_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .req        (req),
      .addr       (req_addr),
      .wsel_cfg   (cfg_q[WSEL_LO +: WSEL_W]),
      .expansion  (bus_pins_en),
      .ext_wait_n (ext_wait_n),
      .busy       (busy),
      .done       (done)
   );

   assign cfg_rdata = cfg_q;

   assert_hia_needs_bus_R11: assert property (@(posedge clk) disable iff (!rst_n)
      hi_addr_en |-> (bus_pins_en && cfg_rdata[HIA_BIT]));
endmodule

// File: tb/xbus_wait_ctrl_bench.sv
module xbus_wait_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [7:0]  cfg_mask = '0;
   logic [7:0]  cfg_wdata = '0;
   logic [7:0]  cfg_rdata;
   logic        req = 1'b0;
   logic [19:0] req_addr = '0;
   logic        ext_wait_n = 1'b1;
   logic        busy, done, bus_pins_en, hi_addr_en, fast_fetch;

   int n_cmp = 0;
   int n_bad = 0;
   logic [7:0] model = 8'h20;

   always #4 clk = ~clk;

   xbus_wait_ctrl u_xbus_wait_ctrl (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mask(cfg_mask),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req(req),
      .req_addr(req_addr), .ext_wait_n(ext_wait_n), .busy(busy), .done(done),
      .bus_pins_en(bus_pins_en), .hi_addr_en(hi_addr_en), .fast_fetch(fast_fetch)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] apply_wr(input logic [7:0] cur, input logic [7:0] m,
                                           input logic [7:0] d);
      return ((cur & ~m) | (d & m)) & 8'hF7;
   endfunction

   function automatic int exp_lat(input logic [7:0] cfg, input logic [19:0] a, input int lw);
      if (cfg[2:0] != 3'b111) return 1;
      if (a[19:16] != 4'h0) return 3;
      if (cfg[5:4] == 2'b11) return lw + 3;
      return int'(cfg[5:4]) + 3;
   endfunction

   task automatic chk_pins();
      chk("R10 bus_pins_en", int'(bus_pins_en), int'(model[2:0] == 3'b111));
      chk("R11 hi_addr_en", int'(hi_addr_en), int'(model[2:0] == 3'b111 && model[6]));
      chk("R12 fast_fetch", int'(fast_fetch), int'(model[7]));
   endtask

   task automatic wr_cfg(input logic [7:0] m, input logic [7:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_mask = m; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      model = apply_wr(model, m, d);
      chk("R2 readback", int'(cfg_rdata), int'(model));
      chk("R3 bit3 zero", int'(cfg_rdata[3]), 0);
      chk_pins();
   endtask

   task automatic run_acc(input logic [19:0] a, input int lw,
                          input bit same_wr, input bit mid_wr, input logic [7:0] wval);
      int exp, k, got;
      bit pin;
      exp = exp_lat(model, a, lw);
      pin = (model[2:0] == 3'b111) && (a[19:16] == 4'h0) && (model[5:4] == 2'b11);
      @(negedge clk);
      req = 1'b1; req_addr = a;
      ext_wait_n = !(pin && lw > 0) ? 1'b1 : 1'b0;
      if (same_wr) begin
         cfg_we = 1'b1; cfg_mask = 8'h30; cfg_wdata = wval;
      end
      k = 0; got = -1;
      while (k < 60) begin
         @(posedge clk);
         @(negedge clk);
         k++;
         if (k == 1) begin
            req = 1'b0;
            if (same_wr) begin
               cfg_we = 1'b0;
               model = apply_wr(model, 8'h30, wval);
               chk("R9 same-edge write readback", int'(cfg_rdata), int'(model));
            end
            if (mid_wr) begin
               cfg_we = 1'b1; cfg_mask = 8'h30; cfg_wdata = wval;
            end
            chk("R8 busy after accept", int'(busy), int'(exp > 1));
         end
         if (k == 2 && mid_wr) begin
            cfg_we = 1'b0;
            model = apply_wr(model, 8'h30, wval);
         end
         if (pin && k == lw + 1) ext_wait_n = 1'b1;
         if (done) begin
            got = k;
            break;
         end
      end
      if (k == 1 && mid_wr) begin
         @(negedge clk);
         cfg_we = 1'b0;
         model = apply_wr(model, 8'h30, wval);
      end
      if (same_wr || mid_wr)
         chk("R9 latency with write during access", got, exp);
      else if (model[2:0] != 3'b111)
         chk("R7 single-chip latency", got, exp);
      else if (a[19:16] != 4'h0)
         chk("R5 upper-space latency", got, exp);
      else if (pin)
         chk("R6 wait-pin latency", got, exp);
      else
         chk("R4 programmed latency", got, exp);
      chk("R8 busy low with done", int'(busy), 0);
      @(negedge clk);
      chk("R8 done one cycle", int'(done), 0);
      ext_wait_n = 1'b1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd7741));
      repeat (3) @(negedge clk);
      chk("R1 reset value", int'(cfg_rdata), 8'h20);
      chk("R8 done low at reset", int'(done), 0);
      chk_pins();
      rst_n = 1'b1;
      @(negedge clk);

      // R7: reset mode is single-chip
      run_acc(20'h00100, 0, 0, 0, 8'h00);
      wr_cfg(8'h07, 8'h05);          // R10 non-expansion mode
      run_acc(20'h00200, 0, 0, 0, 8'h00);

      wr_cfg(8'hFF, 8'h0F);          // R3 write to bit 3 ignored, wsel 00
      run_acc(20'h01234, 0, 0, 0, 8'h00);
      wr_cfg(8'h30, 8'h10);
      run_acc(20'h0FFFF, 0, 0, 0, 8'h00);
      wr_cfg(8'h30, 8'h20);
      run_acc(20'h00000, 0, 0, 0, 8'h00);
      run_acc(20'h10000, 0, 0, 0, 8'h00);   // R5 boundary
      wr_cfg(8'h30, 8'h30);
      run_acc(20'h00040, 0, 0, 0, 8'h00);   // R6 no low samples
      run_acc(20'h00040, 4, 0, 0, 8'h00);
      run_acc(20'hF0040, 4, 0, 0, 8'h00);   // R5 pin ignored upstairs
      wr_cfg(8'hC0, 8'hC0);          // R11 R12
      wr_cfg(8'h40, 8'h00);          // R2 single-bit clear

      wr_cfg(8'h30, 8'h20);
      run_acc(20'h00010, 0, 1, 0, 8'h00);   // R9 same-edge write
      run_acc(20'h00010, 0, 0, 1, 8'h20);   // R9 mid-access write
      wr_cfg(8'h30, 8'h00);
      run_acc(20'h00010, 0, 1, 0, 8'h30);

      for (int i = 0; i < 40; i++) begin
         logic [7:0] m, d;
         logic [19:0] a;
         m = 8'($urandom());
         d = 8'($urandom());
         if (($urandom() % 3) != 0) d[2:0] = 3'b111;
         wr_cfg(m, d);
         a = 20'($urandom());
         if ($urandom() % 2 != 0) a[19:16] = 4'h0;
         run_acc(a, int'($urandom() % 6), 0, 0, 8'h00);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule